// File: doc/BRIEF.md
# Configuration Register Write Loader

This block builds a 32-bit configuration word out of host writes and makes it visible all at once. The host can deliver the word in three ways, chosen by two mode straps. In parallel word mode it makes two 16-bit writes. In parallel byte mode it makes four 8-bit writes on the upper half of the data bus. In serial mode it sends a framed bit stream. Every input is synchronous to the block clock. Strobes, frame and serial clock are detected by edge detection inside the block.

A piece counter tracks which slice of the word the next parallel write fills. Finished slices are kept in a hidden shadow register. The visible register changes only in the cycle the final piece arrives, so a half-written word never reaches the outputs. Two control flags are decoded from the visible word:
- an external conversion clock select;
- a sequential (interleaved) mode flag. This flag is only active when the external clock is also selected.

The serial path is a three-state machine:
- `SER_IDLE` moves to `SER_SHIFT` on a frame start.
- `SER_SHIFT` moves to `SER_DONE` on the 32nd bit. It falls back to `SER_IDLE` on an early frame end, which discards the frame.
- `SER_DONE` moves to `SER_IDLE` on frame end.
- A mode change, or leaving serial mode, forces `SER_IDLE` from any state.

Top module: `cfg_write_loader`

## Requirements
- R1: After reset, `cfg_word` is all zeros, both flags are 0, and the parallel piece counter and serial state machine are cleared.
- R2: In word mode (`ser_mode`=0, `byte_mode`=0), the first write supplies bits 31:16 from `data_bus[15:0]`. The second write supplies bits 15:0. `cfg_word` takes the full value one clock after the second write is seen.
- R3: In byte mode (`ser_mode`=0, `byte_mode`=1), four writes on `data_bus[15:8]` supply bits 31:24, 23:16, 15:8 and 7:0, in that order. `data_bus[7:0]` is ignored.
- R4: A parallel write is taken only on a rising edge of `wr_n` while `cs_n` is low. A strobe with `cs_n` high neither changes `cfg_word` nor advances the piece counter.
- R5: `cfg_word` never shows partially written data. It changes only in the cycle after the final piece of a complete update.
- R6: After the last piece, the piece counter returns to the first piece. The next write again supplies the top slice.
- R7: In serial mode (`ser_mode`=1), a frame starts on a falling edge of `fs_n`. `sdi` is sampled on each falling edge of `sclk`, bit 31 first. After the 32nd bit `cfg_word` is loaded, and further bits are ignored until `fs_n` rises.
- R8: A serial frame whose `fs_n` rises before 32 bits have been taken is discarded, and `cfg_word` is unchanged.
- R9: `ext_clk_sel` equals bit 11 of `cfg_word` (1 selects the external conversion clock).
- R10: `seq_active` is 1 only when bits 23 and 11 of `cfg_word` are both 1.
- R11: Any change of the mode straps restarts the piece sequence and the serial state machine. Parallel strobes are ignored in serial mode, and serial frames are ignored in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_mode | input | 1 | Strap: 1 selects serial loading, 0 selects parallel loading |
| byte_mode | input | 1 | Strap: in parallel mode, 1 selects byte pieces and 0 selects word pieces |
| cs_n | input | 1 | Parallel chip select, active low |
| wr_n | input | 1 | Parallel write strobe; a write is taken on its rising edge |
| data_bus | input | 16 | Parallel write data |
| fs_n | input | 1 | Serial frame, active low |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| cfg_word | output | 32 | Visible configuration word |
| ext_clk_sel | output | 1 | External conversion clock selected |
| seq_active | output | 1 | Sequential mode in effect |

## Verification
Each strobe, frame or serial clock edge is seen by a one-register edge detector. The completing write or 32nd bit is committed at the first clock edge at which the new input level is present. As a result, `cfg_word` and the two flags change exactly one clock after the host drives the edge.

The bench holds every driven level for two clocks and samples only on falling clock edges after that window. Each check therefore sees the settled result. The bench also checks the unchanged value after every non-final piece, so early exposure of partial data would be caught.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_DONE  = 2'd2
    } ser_state_e;
endpackage

// File: rtl/cfgw_edge.sv
module cfgw_edge #(
    parameter bit RST_VAL     = 1'b1,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig_in;
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign pulse = !prev_q && sig_in;
        end else begin : g_fall
            assign pulse = prev_q && !sig_in;
        end
    endgenerate
endmodule

// File: rtl/cfgw_par_asm.sv
module cfgw_par_asm #(
    parameter int REG_W  = 32,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             byte_mode,
    input  logic             restart,
    input  logic             wr_take,
    input  logic [BUS_W-1:0] bus,
    output logic             commit,
    output logic [REG_W-1:0] commit_word
);
    localparam int WORD_PIECES = REG_W / BUS_W;
    localparam int BYTE_PIECES = REG_W / BYTE_W;
    localparam int CNT_W       = $clog2(BYTE_PIECES);

    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] shadow_q;
    logic [REG_W-1:0] merged;
    logic             last_piece;
    logic             take;
    int               base;

    assign last_piece = byte_mode ? (cnt_q == CNT_W'(BYTE_PIECES - 1))
                                  : (cnt_q == CNT_W'(WORD_PIECES - 1));
    assign take = en && wr_take && !restart;

    always_comb begin
        merged = shadow_q;
        if (byte_mode) begin
            base = REG_W - BYTE_W * (int'(cnt_q) + 1);
            merged[base +: BYTE_W] = bus[BUS_W-1 -: BYTE_W];
        end else begin
            base = REG_W - BUS_W * (int'(cnt_q) + 1);
            merged[base +: BUS_W] = bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (restart || !en) begin
            cnt_q    <= '0;
        end else if (take) begin
            shadow_q <= merged;
            cnt_q    <= last_piece ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        commit      = take && last_piece;
        commit_word = merged;
    end

    a_r6_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> cnt_q == '0);
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && !byte_mode) |-> cnt_q < CNT_W'(WORD_PIECES));
    a_r5_step_on_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last_piece) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_take && en && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/cfgw_ser_fsm.sv
module cfgw_ser_fsm #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             bit_strobe,
    input  logic             sdi,
    output logic             commit,
    output logic [REG_W-1:0] commit_word
);
    import cfgw_pkg::*;

    localparam int CNT_W = $clog2(REG_W);

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] bitcnt_q;
    logic [REG_W-1:0] shreg_q;
    logic             last_bit;
    logic             shift_now;

    assign last_bit  = bitcnt_q == CNT_W'(REG_W - 1);
    assign shift_now = (state_q == SER_SHIFT) && bit_strobe && !frame_end;

    always_comb begin
        state_d = state_q;
        if (!en || restart) begin
            state_d = SER_IDLE;
        end else begin
            unique case (state_q)
                SER_IDLE:  if (frame_start) state_d = SER_SHIFT;
                SER_SHIFT: begin
                    if (frame_end)                  state_d = SER_IDLE;
                    else if (bit_strobe && last_bit) state_d = SER_DONE;
                end
                SER_DONE:  if (frame_end) state_d = SER_IDLE;
                default:   state_d = SER_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SER_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != SER_SHIFT) begin
                bitcnt_q <= '0;
            end else if (shift_now) begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shreg_q  <= {shreg_q[REG_W-2:0], sdi};
            end
        end
    end

    always_comb begin
        commit      = en && !restart && shift_now && last_bit;
        commit_word = {shreg_q[REG_W-2:0], sdi};
    end

    a_r7_commit_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> state_q == SER_DONE);
    a_r8_early_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && state_q == SER_SHIFT && frame_end) |=> state_q == SER_IDLE);
    a_r11_serial_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == SER_IDLE);
    a_r7_done_ignores_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_DONE) |-> !commit);
endmodule

// File: rtl/cfg_write_loader.sv
module cfg_write_loader #(
    parameter int REG_W      = 32,
    parameter int BUS_W      = 16,
    parameter int BYTE_W     = 8,
    parameter int EXTCLK_BIT = 11,
    parameter int SEQ_BIT    = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_mode,
    input  logic             byte_mode,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] data_bus,
    input  logic             fs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic [REG_W-1:0] cfg_word,
    output logic             ext_clk_sel,
    output logic             seq_active
);
    logic [1:0]       straps_q;
    logic             restart;
    logic             wr_rise;
    logic             fs_fall;
    logic             fs_rise;
    logic             sclk_fall;
    logic             par_commit;
    logic             ser_commit;
    logic [REG_W-1:0] par_word;
    logic [REG_W-1:0] ser_word;
    logic [REG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) straps_q <= 2'b00;
        else        straps_q <= {ser_mode, byte_mode};
    end
    assign restart = straps_q != {ser_mode, byte_mode};

    cfgw_edge #(.RST_VAL(1'b1), .DETECT_RISE(1'b1)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(wr_n), .pulse(wr_rise));
    cfgw_edge #(.RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_fs_start (
        .clk(clk), .rst_n(rst_n), .sig_in(fs_n), .pulse(fs_fall));
    cfgw_edge #(.RST_VAL(1'b1), .DETECT_RISE(1'b1)) u_fs_end (
        .clk(clk), .rst_n(rst_n), .sig_in(fs_n), .pulse(fs_rise));
    cfgw_edge #(.RST_VAL(1'b0), .DETECT_RISE(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(sclk), .pulse(sclk_fall));

    cfgw_par_asm #(.REG_W(REG_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_par (
        .clk(clk), .rst_n(rst_n), .en(!ser_mode), .byte_mode(byte_mode),
        .restart(restart), .wr_take(wr_rise && !cs_n), .bus(data_bus),
        .commit(par_commit), .commit_word(par_word));

    cfgw_ser_fsm #(.REG_W(REG_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .en(ser_mode), .restart(restart),
        .frame_start(fs_fall), .frame_end(fs_rise), .bit_strobe(sclk_fall),
        .sdi(sdi), .commit(ser_commit), .commit_word(ser_word));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cfg_q <= '0;
        else if (par_commit) cfg_q <= par_word;
        else if (ser_commit) cfg_q <= ser_word;
    end

    assign cfg_word    = cfg_q;
    assign ext_clk_sel = cfg_q[EXTCLK_BIT];
    assign seq_active  = cfg_q[SEQ_BIT] && cfg_q[EXTCLK_BIT];

    a_r5_change_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(par_commit || ser_commit));
    a_r11_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_commit, ser_commit}));
    a_r10_seq_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> ext_clk_sel);
    a_r4_no_write_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !par_commit);
endmodule

// File: tb/cfg_write_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_write_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_mode = 1'b0;
    logic        byte_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] data_bus = '0;
    logic        fs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [31:0] cfg_word;
    logic        ext_clk_sel;
    logic        seq_active;

    int checks = 0;
    int failures = 0;
    logic [31:0] expv = '0;

    always #4 clk = ~clk;

    cfg_write_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .byte_mode(byte_mode),
        .cs_n(cs_n), .wr_n(wr_n), .data_bus(data_bus), .fs_n(fs_n),
        .sclk(sclk), .sdi(sdi), .cfg_word(cfg_word),
        .ext_clk_sel(ext_clk_sel), .seq_active(seq_active));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        checks++;
        if (ext_clk_sel !== expv[11] || seq_active !== (expv[23] & expv[11])) begin
            failures++;
            $display("FAIL %s actual=%b%b expected=%b%b", tag, ext_clk_sel, seq_active,
                     expv[11], expv[23] & expv[11]);
        end
    endtask

    task automatic par_write(input logic [15:0] d, input logic sel);
        data_bus = d; cs_n = !sel; wr_n = 1'b0; tick(2);
        wr_n = 1'b1; tick(2);
        cs_n = 1'b1; tick(1);
    endtask

    task automatic ser_frame(input logic [31:0] w, input int nbits);
        fs_n = 1'b0; tick(2);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 32) ? w[31-i] : i[0];
            sclk = 1'b1; tick(2);
            sclk = 1'b0; tick(2);
        end
        fs_n = 1'b1; tick(2);
    endtask

    task automatic set_mode(input logic s, input logic b);
        ser_mode = s; byte_mode = b; tick(3);
    endtask

    task automatic word_load(input logic [31:0] v, input string tag);
        par_write(v[31:16], 1'b1);
        chk32("R5 partial word hidden", cfg_word, expv);
        par_write(v[15:0], 1'b1);
        expv = v;
        chk32(tag, cfg_word, expv);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk32("R1 reset value", cfg_word, 32'h0);
        chk_flags("R1 reset flags");

        // R2, R9, R10: word mode sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = (32'h9E3779B9 * (k + 1)) ^ 32'h13579BDF;
            word_load(v, "R2 word mode value");
            chk_flags("R9 R10 flags word mode");
        end

        // R9, R10: all four combinations of bits 11 and 23
        for (int b = 0; b < 4; b++) begin
            logic [31:0] v;
            v = 32'h3C3CC3C3 & ~32'h00800800;
            v[11] = b[0];
            v[23] = b[1];
            word_load(v, "R9 R10 flag sweep value");
            chk_flags("R9 R10 flag sweep");
        end

        // R4: deselected strobe neither loads nor advances the counter
        par_write(16'hDEAD, 1'b0);
        chk32("R4 deselected write ignored", cfg_word, expv);
        word_load(32'hCAFE1234, "R4 counter not advanced");

        // R3, R6: byte mode, lower lines carry junk
        set_mode(1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            logic [31:0] v;
            v = (32'h7F4A7C15 * (k + 3)) + 32'h01234567;
            for (int p = 0; p < 4; p++) begin
                par_write({v[31-8*p -: 8], 8'hA5}, 1'b1);
                if (p < 3) chk32("R5 partial byte hidden", cfg_word, expv);
            end
            expv = v;
            chk32("R3 R6 byte mode value", cfg_word, expv);
            chk_flags("R9 R10 flags byte mode");
        end

        // R11: strap change restarts sequence
        par_write(16'h1100, 1'b1);
        par_write(16'h2200, 1'b1);
        set_mode(1'b0, 1'b0);
        word_load(32'hA5C3_0F1E, "R11 restart after mode change");

        // R11: parallel strobes ignored in serial mode
        set_mode(1'b1, 1'b0);
        par_write(16'hFFFF, 1'b1);
        par_write(16'hFFFF, 1'b1);
        chk32("R11 parallel ignored in serial", cfg_word, expv);

        // R7: serial sweep
        for (int k = 0; k < 6; k++) begin
            logic [31:0] v;
            v = (32'h85EBCA6B * (k + 1)) ^ (32'h00800800 * k[0]);
            ser_frame(v, 32);
            expv = v;
            chk32("R7 serial value", cfg_word, expv);
            chk_flags("R9 R10 flags serial");
        end

        // R8: short frame discarded
        ser_frame(32'h0BADF00D, 20);
        chk32("R8 short frame discarded", cfg_word, expv);
        ser_frame(32'h12345678, 31);
        chk32("R8 31-bit frame discarded", cfg_word, expv);

        // R7: extra bits after the 32nd ignored
        ser_frame(32'hF00DFACE, 37);
        expv = 32'hF00DFACE;
        chk32("R7 extra bits ignored", cfg_word, expv);

        // R11: serial frame ignored in parallel mode
        set_mode(1'b0, 1'b0);
        ser_frame(32'h55AA55AA, 32);
        chk32("R11 serial ignored in parallel", cfg_word, expv);

        // R6: wrap in word mode then new update
        word_load(32'h00800800, "R6 wrap word mode");
        chk_flags("R10 both bits set");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule